// File: doc/BRIEF.md
# Edge-Polarity GPIO Port with Interrupt

A sixteen-pin general-purpose I/O port controlled through a small 16-bit register interface. Each pin is either an input or an output. Output pins present a latched value with their output enable asserted; input pins are sampled through a two-flop synchronizer. Each input pin can raise an interrupt on one edge, rising or falling, chosen per pin.

A detected edge on an unmasked input pin sets a sticky status bit. The single interrupt request stays high while any status bit is set. Software clears status bits by writing ones to them. A pin-control register gates what the data-input read returns. Only 16-bit accesses take effect. Each access is one cycle long, with `bus_half` marking it as 16-bit. Read data is combinational from the current register state.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output latch, direction, edge-polarity, mask and pin-control registers read 0xFFFF; the status register, the data-input read and `irq` are 0.
- R2: Byte offsets: 0x04 output latch, 0x08 direction, 0x0C edge polarity, 0x10 mask, 0x14 status, 0x18 pin control, 0x00 data input. All except 0x00 read back their full 16-bit value. Offset 0x00 is read-only and writes to it change nothing.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` bit low). A bit of 0 makes it an output: `pin_oe` is high and `pin_out` shows the latched output bit. This holds from the cycle after the write.
- R4: A read of offset 0x00 returns the synchronized pin values ANDed with pin control. A pin change is visible there after two clock edges.
- R5: A polarity bit of 1 selects a 0-to-1 transition and a bit of 0 selects a 1-to-0 transition. The selected edge on an unmasked input pin sets that status bit and raises `irq` on the third clock edge after the pin changes.
- R6: A pin whose mask bit is 1, or whose direction bit is 0, never sets its status bit.
- R7: Writing the status register clears each bit written as 1. `irq` stays high while any status bit remains set, and drops on the edge where the last bit clears.
- R8: If an edge is detected in the same cycle as a write that clears that pin's status bit, the bit stays set.
- R9: A write with `bus_half` low changes no register. A read with `bus_half` low returns 0.
- R10: Offsets outside the map read as 0 and ignore writes. This includes 0x1C and 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = 16-bit access; other sizes are ignored |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational |
| pin_in | input | WIDTH | Asynchronous pin inputs |
| pin_out | output | WIDTH | Output latch value |
| pin_oe | output | WIDTH | Per-pin output enable (inverse of direction) |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach from the ports is a clearing write to the status register landing in exactly the cycle where the synchronizer first presents a new edge for that pin. The bench reaches it with a directed sequence. It toggles a pin on a falling clock edge, counts two rising edges through the synchronizer, and issues the clearing write for the third edge. A randomized sequence then interleaves register writes, wrong-size writes, unmapped accesses and pin changes. It compares every readback against a bench model that derives status bits by walking the pins one at a time.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned OFF_BITS = 5;
  localparam logic [OFF_BITS-1:0] OFF_DIN  = 5'h00;
  localparam logic [OFF_BITS-1:0] OFF_OUT  = 5'h04;
  localparam logic [OFF_BITS-1:0] OFF_DIR  = 5'h08;
  localparam logic [OFF_BITS-1:0] OFF_POL  = 5'h0C;
  localparam logic [OFF_BITS-1:0] OFF_MASK = 5'h10;
  localparam logic [OFF_BITS-1:0] OFF_STAT = 5'h14;
  localparam logic [OFF_BITS-1:0] OFF_PCTL = 5'h18;

  typedef enum logic [2:0] {
    SEL_DIN, SEL_OUT, SEL_DIR, SEL_POL, SEL_MASK, SEL_STAT, SEL_PCTL, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [OFF_BITS-1:0] off);
    case (off)
      OFF_DIN:  return SEL_DIN;
      OFF_OUT:  return SEL_OUT;
      OFF_DIR:  return SEL_DIR;
      OFF_POL:  return SEL_POL;
      OFF_MASK: return SEL_MASK;
      OFF_STAT: return SEL_STAT;
      OFF_PCTL: return SEL_PCTL;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_async,
  output logic [WIDTH-1:0] pins_now,
  output logic [WIDTH-1:0] pins_prev
);
  logic [WIDTH-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pins_async;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign pins_now  = stage2_q;
  assign pins_prev = prev_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] rise_sel,
  input  logic [WIDTH-1:0] is_input,
  input  logic [WIDTH-1:0] masked,
  output logic [WIDTH-1:0] hits
);
  function automatic logic [WIDTH-1:0] edge_hits(
    input logic [WIDTH-1:0] c, p, pol, dir, msk);
    logic [WIDTH-1:0] rose, fell;
    rose = c & ~p;
    fell = ~c & p;
    return ((pol & rose) | (~pol & fell)) & dir & ~msk;
  endfunction

  assign hits = edge_hits(cur, prev, rise_sel, is_input, masked);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_bits,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] status,
  output logic             irq
);
  logic [WIDTH-1:0] st_q, st_next;
  logic             irq_q;

  // a set in the same cycle as a clear wins
  assign st_next = (st_q & ~clr_bits) | set_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_next;
      irq_q <= |st_next;
    end
  end

  assign status = st_q;
  assign irq    = irq_q;

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(st_q) & ~$past(clr_bits) & ~st_q) == '0));

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> (st_q == '0));

  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(set_bits) != '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_bits) & ~st_q) == '0));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] out_q, dir_q, pol_q, mask_q, pctl_q;
  logic [WIDTH-1:0] sync_now, sync_prev, edge_hits, status, clr_bits;
  reg_sel_e         sel;
  logic             wr_ok, rd_ok;

  assign sel   = decode_off(OFF_BITS'(bus_addr));
  assign wr_ok = bus_valid & bus_write & bus_half;
  assign rd_ok = bus_valid & ~bus_write & bus_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= ALL_ONES;
      dir_q  <= ALL_ONES;
      pol_q  <= ALL_ONES;
      mask_q <= ALL_ONES;
      pctl_q <= ALL_ONES;
    end else if (wr_ok) begin
      case (sel)
        SEL_OUT:  out_q  <= bus_wdata;
        SEL_DIR:  dir_q  <= bus_wdata;
        SEL_POL:  pol_q  <= bus_wdata;
        SEL_MASK: mask_q <= bus_wdata;
        SEL_PCTL: pctl_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign clr_bits = (wr_ok && sel == SEL_STAT) ? bus_wdata : '0;

  gpio_pin_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_async(pin_in),
    .pins_now(sync_now), .pins_prev(sync_prev)
  );

  gpio_edge_detect #(.WIDTH(WIDTH)) u_edge (
    .cur(sync_now), .prev(sync_prev), .rise_sel(pol_q),
    .is_input(dir_q), .masked(mask_q), .hits(edge_hits)
  );

  gpio_irq_status #(.WIDTH(WIDTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_bits(edge_hits), .clr_bits(clr_bits),
    .status(status), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (sel)
        SEL_DIN:  bus_rdata = sync_now & pctl_q;
        SEL_OUT:  bus_rdata = out_q;
        SEL_DIR:  bus_rdata = dir_q;
        SEL_POL:  bus_rdata = pol_q;
        SEL_MASK: bus_rdata = mask_q;
        SEL_STAT: bus_rdata = status;
        SEL_PCTL: bus_rdata = pctl_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  assert_wrong_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !bus_half) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(pol_q) &&
       $stable(mask_q) && $stable(pctl_q)));

  assert_input_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status & ~$past(status)) & ($past(~dir_q) | $past(mask_q))) == '0));
endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  localparam int W = 16;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0, bus_half = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic irq;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [W-1:0] m_out, m_dir, m_pol, m_mask, m_st, m_pc, m_pins;

  gpio_edge_port #(.WIDTH(W), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  always #5ns clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_edges(input logic [W-1:0] old_p, input logic [W-1:0] new_p);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      if (m_dir[i] && !m_mask[i]) begin
        if (m_pol[i]) r[i] = !old_p[i] && new_p[i];
        else          r[i] = old_p[i] && !new_p[i];
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      5'h00: return m_pins & m_pc;
      5'h04: return m_out;
      5'h08: return m_dir;
      5'h0C: return m_pol;
      5'h10: return m_mask;
      5'h14: return m_st;
      5'h18: return m_pc;
      default: return '0;
    endcase
  endfunction

  task automatic bus_wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic half);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_half = half; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    if (half) begin
      case (a)
        5'h04: m_out = d;
        5'h08: m_dir = d;
        5'h0C: m_pol = d;
        5'h10: m_mask = d;
        5'h14: m_st = m_st & ~d;
        5'h18: m_pc = d;
        default: ;
      endcase
    end
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic half, output logic [W-1:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_half = half; bus_addr = a;
    #1ns d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic check_reg(input string req, input logic [AW-1:0] a);
    logic [W-1:0] d;
    bus_rd(a, 1'b1, d);
    check(req, d, model_read(a));
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 7; k++) check_reg(req, AW'(k * 4));
    check({req, " pin_out"}, pin_out, m_out);
    check({req, " pin_oe"}, pin_oe, ~m_dir);
    check({req, " irq"}, W'(irq), W'(m_st != '0));
  endtask

  task automatic drive_pins(input logic [W-1:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (4) @(negedge clk);
    m_st = m_st | model_edges(m_pins, p);
    m_pins = p;
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'h5eed_0017));
    m_out = '1; m_dir = '1; m_pol = '1; m_mask = '1; m_st = '0; m_pc = '1; m_pins = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset values
    check_all("R1 reset");

    // R2/R3 register map and output pins
    bus_wr(5'h04, 16'hA5C3, 1); bus_wr(5'h08, 16'h0F0F, 1);
    check("R3 oe", pin_oe, 16'hF0F0);
    check("R3 out", pin_out, 16'hA5C3);
    bus_wr(5'h00, 16'h1234, 1);           // R2 read-only offset
    check_all("R2 map");

    // R4 data-input gated by pin control
    bus_wr(5'h18, 16'h00FF, 1);
    drive_pins(16'h3C3C);
    check_reg("R4 din", 5'h00);

    // R5 rising on pin 0, falling on pin 1, check exact cycle
    bus_wr(5'h08, 16'hFFFF, 1); bus_wr(5'h0C, 16'hFFFD, 1); bus_wr(5'h10, 16'h0000, 1);
    drive_pins(16'h0002);
    bus_wr(5'h14, 16'hFFFF, 1);
    check_all("R5 settle");
    @(negedge clk) pin_in = 16'h0001;
    @(negedge clk); @(negedge clk);
    check("R5 not yet", W'(irq), 16'h0000);
    @(negedge clk);
    check("R5 irq on 3rd edge", W'(irq), 16'h0001);
    m_st = m_st | model_edges(m_pins, 16'h0001); m_pins = 16'h0001;
    check_reg("R5 status rise+fall", 5'h14);

    // R7 partial clear keeps irq, full clear drops it
    bus_wr(5'h14, 16'h0001, 1);
    check("R7 partial irq", W'(irq), 16'h0001);
    check_reg("R7 partial status", 5'h14);
    bus_wr(5'h14, 16'h0002, 1);
    check("R7 full irq", W'(irq), 16'h0000);

    // R6 masked and output pins ignore edges
    bus_wr(5'h10, 16'h0004, 1); bus_wr(5'h08, 16'hFFF7, 1);
    drive_pins(16'h000D);
    check_reg("R6 masked/output", 5'h14);
    check("R6 irq", W'(irq), 16'h0000);

    // R8 set and clear collide in one cycle
    bus_wr(5'h10, 16'h0000, 1); bus_wr(5'h08, 16'hFFFF, 1); bus_wr(5'h0C, 16'hFFFF, 1);
    drive_pins(16'h0000);
    bus_wr(5'h14, 16'hFFFF, 1);
    @(negedge clk) pin_in = 16'h0010;
    @(negedge clk);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_half = 1; bus_addr = 5'h14; bus_wdata = 16'h0010;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    m_pins = 16'h0010; m_st = 16'h0010;
    check_reg("R8 set wins", 5'h14);
    check("R8 irq", W'(irq), 16'h0001);
    bus_wr(5'h14, 16'hFFFF, 1);

    // R9 wrong-size write and read
    bus_wr(5'h04, 16'h0000, 0); bus_wr(5'h10, 16'h5555, 0);
    check_all("R9 write ignored");
    bus_rd(5'h08, 1'b0, d);
    check("R9 read zero", d, 16'h0000);

    // R10 unmapped offsets
    bus_wr(5'h1C, 16'h0000, 1); bus_wr(5'h02, 16'h0000, 1);
    bus_rd(5'h1C, 1'b1, d); check("R10 read 1C", d, 16'h0000);
    bus_rd(5'h02, 1'b1, d); check("R10 read 02", d, 16'h0000);
    check_all("R10 write ignored");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [AW-1:0] a = AW'($urandom_range(0, 6) * 4);
        bus_wr(a, W'($urandom), 1);
      end else if (op < 7) begin
        drive_pins(W'($urandom));
      end else if (op == 7) begin
        bus_wr(AW'($urandom_range(0, 6) * 4), W'($urandom), 0);
      end else if (op == 8) begin
        bus_wr(AW'($urandom_range(7, 31)) | 5'h01, W'($urandom), 1);
      end else begin
        check_reg("R2 random read", AW'($urandom_range(0, 6) * 4));
      end
      if (it % 40 == 39) check_all("R5 random sweep");
    end
    check_all("R7 final");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule